// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes one incoming Ethernet frame at a time from a byte stream and stores it in host memory. Buffer locations come from a ring of receive descriptors, each four 32-bit words, that software prepares in memory. For every frame the engine reads the descriptor at its current pointer and checks that the descriptor belongs to hardware. It then fills the descriptor's first buffer and, when the second pointer is a plain buffer, the second buffer as well. It writes a status word back into the descriptor and moves the pointer on. Four placeholder check-sequence bytes, written as zeros, follow each frame in memory and are included in the stored length.

All memory traffic goes through one master port. Each access is a single 32-bit read or write beat. The request and its address, data and strobes stay unchanged until the memory raises ready. Frame bytes arrive on a valid/ready stream, and `s_last` marks the final byte. A byte moves on a clock edge where `s_valid` and `s_ready` are both high. The source must hold a byte stable while `s_ready` is low. The engine lowers `s_ready` while it fetches descriptors, writes words or writes status back, and while it adds the check-sequence bytes. When it has to discard a frame it holds `s_ready` high until `s_last`. A 3-bit process state and single-cycle receive-interrupt and receive-unavailable pulses go to a separate status block.

Top module: `rxring_dma`

## Requirements
- R1: A frame is started only when `mac_rx_en` and `dma_rx_start` are both high. Otherwise `s_ready` stays low, no memory request is made, and `proc_state` reads 0 (stopped). When enabled and idle, `proc_state` reads 3 (waiting).
- R2: If `desc_ptr` is zero when a frame starts, it is first loaded from `ring_base`. `desc_ptr` then gives the address of the descriptor to be used by the next frame.
- R3: A descriptor is read as four beats, at pointer+0, +4, +8 and +12. If bit 31 (hardware owns) of word 0 of the first descriptor of a frame is 0, the engine pulses `ev_ru` and `ev_ri` and reports state 4 (suspended). It then discards the whole frame with no memory write and leaves `desc_ptr` unchanged.
- R4: The stored byte count is the frame length plus 4, and the 4 extra bytes are zeros. Byte n of a buffer goes to buffer address + n, with the low two address bits ignored and little-endian lanes. A partial final word enables only the lanes it fills.
- R5: Word 1 bits [10:0] give the buffer 1 size and bits [21:11] the buffer 2 size. Word 2 is the buffer 1 address. Each buffer takes the smaller of its size and the bytes still to store. Word 3 is used as buffer 2 only when word 1 bit 24 (chained) is 0 and bytes remain after buffer 1.
- R6: The next descriptor address is chosen in priority order. If word 1 bit 25 (end of ring) is set it is `ring_base`. Otherwise, if bit 24 is set, it is word 3. Otherwise it is the current address + 16.
- R7: When a descriptor is finished, one beat writes its word 0. Bit 31 is 0 and bits [29:16] hold the cumulative byte count of the frame. Bit 9 is set in the frame's first descriptor and bit 8 in its last. All other bits are 0 except the bit 14 described in R8.
- R8: If a continuation descriptor is software-owned, the frame ends there. Its word 0 is written with bit 8 set, the cumulative count, and bit 14 (descriptor error) set unless `flush_ctl` is high. The rest of the frame is discarded.
- R9: At frame end `ev_ri` pulses unless bit 31 of word 1 of the frame's final descriptor is set.
- R10: For a stored frame, `proc_state` runs 1 (fetching), 7 (transferring), 5 (closing), then 3 (waiting).
- R11: A memory request keeps its address, direction, data and strobes stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_rx_en | input | 1 | MAC receive enable |
| dma_rx_start | input | 1 | DMA receive run enable |
| flush_ctl | input | 1 | Suppresses the descriptor-error flag when set |
| ring_base | input | 32 | Descriptor ring base address (word aligned) |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Final byte of frame |
| s_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte strobes |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Beat completes on this edge |
| proc_state | output | 3 | Receive process state code |
| ev_ri | output | 1 | Receive-interrupt event pulse |
| ev_ru | output | 1 | Receive-unavailable event pulse |
| desc_ptr | output | 32 | Current descriptor pointer |

## Verification
The hardest case to reach is a software-owned descriptor in the middle of a frame. The frame has to fill the first descriptor completely while bytes are still waiting at the stream edge, so the engine meets the unowned descriptor with the frame only half taken. The bench forces this with a 4-byte single buffer followed by a zeroed descriptor and a 10-byte frame, once with `flush_ctl` low and once high. It then checks the error bit, the end marker, the discarded tail and the untouched memory beyond the buffer. Ring wrap, chained links and two-buffer splits are reached by laying descriptors so that successive frames walk through each next-address case in turn.

// File: rtl/rxdma_pkg.sv
`timescale 1ns/1ps
package rxdma_pkg;

  typedef enum logic [2:0] {
    PS_STOPPED = 3'd0,
    PS_FETCH   = 3'd1,
    PS_WAIT    = 3'd3,
    PS_SUSP    = 3'd4,
    PS_CLOSE   = 3'd5,
    PS_XFER    = 3'd7
  } rx_pstate_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_BUFSEL,
    S_XFER,
    S_WDATA,
    S_WBACK,
    S_DROP
  } eng_state_e;

  // status word (word 0) field positions
  localparam int W0_OWN    = 31;
  localparam int W0_LEN_LO = 16;
  localparam int W0_DE     = 14;
  localparam int W0_FS     = 9;
  localparam int W0_LS     = 8;

  // control word (word 1) field positions
  localparam int W1_DIC    = 31;
  localparam int W1_EOR    = 25;
  localparam int W1_CHN    = 24;
  localparam int W1_SZ2_LO = 11;
  localparam int W1_SZ1_LO = 0;

  localparam int DESC_BYTES = 16;

endpackage

// File: rtl/rxdma_byte_packer.sv
`timescale 1ns/1ps
module rxdma_byte_packer #(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [7:0]              din,
  input  logic                    clear,
  output logic [$clog2(LANES)-1:0] lane,
  output logic [8*LANES-1:0]      word,
  output logic [LANES-1:0]        be
);
  localparam int LW = $clog2(LANES);

  logic [LW-1:0] lane_q;
  logic [7:0]    byte_q [LANES];
  logic          be_q   [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lane_q <= '0;
    else if (clear)  lane_q <= '0;
    else if (push)   lane_q <= lane_q + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[g] <= '0;
        be_q[g]   <= 1'b0;
      end else if (clear) begin
        be_q[g]   <= 1'b0;
      end else if (push && lane_q == LW'(g)) begin
        byte_q[g] <= din;
        be_q[g]   <= 1'b1;
      end
    end
    assign word[8*g +: 8] = byte_q[g];
    assign be[g]          = be_q[g];
  end

  assign lane = lane_q;

  // R4
  be_from_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be != '0) |-> be[0]);

endmodule

// File: rtl/rxdma_fcs_pad.sv
`timescale 1ns/1ps
module rxdma_fcs_pad #(
  parameter int PAD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  input  logic       take,
  output logic       src_valid,
  output logic [7:0] src_byte,
  output logic       src_final,
  output logic       padding,
  output logic       stream_done
);
  localparam int PCW = (PAD > 1) ? $clog2(PAD) : 1;

  logic [PCW-1:0] pcnt;
  logic           pad_q;
  logic           done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q  <= 1'b0;
      pcnt   <= '0;
      done_q <= 1'b0;
    end else if (clear) begin
      pad_q  <= 1'b0;
      pcnt   <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      if (pad_q) begin
        if (pcnt == PCW'(PAD - 1)) pad_q <= 1'b0;
        else                      pcnt  <= pcnt + 1'b1;
      end else if (s_last) begin
        pad_q  <= 1'b1;
        pcnt   <= '0;
        done_q <= 1'b1;
      end
    end
  end

  assign src_valid   = pad_q | s_valid;
  assign src_byte    = pad_q ? 8'h00 : s_data;
  assign src_final   = pad_q && (pcnt == PCW'(PAD - 1));
  assign padding     = pad_q;
  assign stream_done = done_q;

  // R4
  pad_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_q) |-> $past(s_valid && s_last));

endmodule

// File: rtl/rxdma_ring_nav.sv
`timescale 1ns/1ps
module rxdma_ring_nav #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  input  logic          end_of_ring,
  input  logic          chained,
  output logic [AW-1:0] next
);
  always_comb begin
    if (end_of_ring)  next = base;
    else if (chained) next = link;
    else              next = cur + AW'(DESC_BYTES);
  end
endmodule

// File: rtl/rxring_dma.sv
`timescale 1ns/1ps
module rxring_dma
  import rxdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LEN_W     = 14,
  parameter int BSZ_W     = 11,
  parameter int FCS_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mac_rx_en,
  input  logic          dma_rx_start,
  input  logic          flush_ctl,
  input  logic [AW-1:0] ring_base,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic [2:0]    proc_state,
  output logic          ev_ri,
  output logic          ev_ru,
  output logic [AW-1:0] desc_ptr
);
  localparam int LANES = 4;
  localparam int LW    = $clog2(LANES);

  eng_state_e st;
  logic [1:0]       fidx;
  logic [AW-1:0]    desc_addr, cur_desc;
  logic             d_own, d_dic, d_eor, d_chn;
  logic [BSZ_W-1:0] d_sz1, d_sz2;
  logic [AW-3:0]    d_b1;
  logic [AW-1:0]    d_link;
  logic             first_desc, bsel, fin, last_flag, de_flag, susp;
  logic [AW-1:0]    buf_addr;
  logic [BSZ_W-1:0] buf_left;
  logic [LEN_W-1:0] total;
  logic             ri_q, ru_q;

  logic             en, start, take;
  logic             src_valid, src_final, padding, stream_done;
  logic [7:0]       src_byte;
  logic [LW-1:0]    lane;
  logic [31:0]      pk_word;
  logic [3:0]       pk_be;
  logic             pk_clear;
  logic [AW-1:0]    nxt;
  logic [31:0]      wb_word;
  rx_pstate_e       ps;

  assign en       = mac_rx_en && dma_rx_start;
  assign start    = (st == S_IDLE) && en && s_valid;
  assign take     = (st == S_XFER) && src_valid;
  assign pk_clear = (st == S_WDATA) && mem_ready;

  rxdma_fcs_pad #(.PAD(FCS_BYTES)) pad_i (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .take(take), .src_valid(src_valid), .src_byte(src_byte),
    .src_final(src_final), .padding(padding), .stream_done(stream_done)
  );

  rxdma_byte_packer #(.LANES(LANES)) pack_i (
    .clk(clk), .rst_n(rst_n), .push(take), .din(src_byte),
    .clear(pk_clear), .lane(lane), .word(pk_word), .be(pk_be)
  );

  rxdma_ring_nav #(.AW(AW), .DESC_BYTES(DESC_BYTES)) nav_i (
    .cur(desc_addr), .base(ring_base), .link(d_link),
    .end_of_ring(d_eor), .chained(d_chn), .next(nxt)
  );

  always_comb begin
    wb_word = '0;
    wb_word[W0_LEN_LO +: LEN_W] = total;
    wb_word[W0_DE] = de_flag;
    wb_word[W0_FS] = first_desc;
    wb_word[W0_LS] = last_flag;
  end

  // memory port mux
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = 4'h0;
    unique case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'({fidx, 2'b00});
        mem_be   = 4'hF;
      end
      S_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_addr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_wdata = wb_word;
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  assign s_ready = ((st == S_XFER) && !padding) || (st == S_DROP);

  // descriptor capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_own  <= 1'b0;
      d_dic  <= 1'b0;
      d_eor  <= 1'b0;
      d_chn  <= 1'b0;
      d_sz1  <= '0;
      d_sz2  <= '0;
      d_b1   <= '0;
      d_link <= '0;
    end else if (st == S_FETCH && mem_ready) begin
      unique case (fidx)
        2'd0: d_own <= mem_rdata[W0_OWN];
        2'd1: begin
          d_dic <= mem_rdata[W1_DIC];
          d_eor <= mem_rdata[W1_EOR];
          d_chn <= mem_rdata[W1_CHN];
          d_sz1 <= mem_rdata[W1_SZ1_LO +: BSZ_W];
          d_sz2 <= mem_rdata[W1_SZ2_LO +: BSZ_W];
        end
        2'd2: d_b1   <= mem_rdata[AW-1:2];
        default: d_link <= mem_rdata[AW-1:0];
      endcase
    end
  end

  // control sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      fidx       <= '0;
      desc_addr  <= '0;
      cur_desc   <= '0;
      first_desc <= 1'b0;
      bsel       <= 1'b0;
      fin        <= 1'b0;
      last_flag  <= 1'b0;
      de_flag    <= 1'b0;
      susp       <= 1'b0;
      buf_addr   <= '0;
      buf_left   <= '0;
      total      <= '0;
      ri_q       <= 1'b0;
      ru_q       <= 1'b0;
    end else begin
      ri_q <= 1'b0;
      ru_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          if (cur_desc == '0) begin
            cur_desc  <= ring_base;
            desc_addr <= ring_base;
          end else begin
            desc_addr <= cur_desc;
          end
          first_desc <= 1'b1;
          total      <= '0;
          fin        <= 1'b0;
          last_flag  <= 1'b0;
          de_flag    <= 1'b0;
          susp       <= 1'b0;
          fidx       <= '0;
          st         <= S_FETCH;
        end
        S_FETCH: if (mem_ready) begin
          if (fidx == 2'd3) st <= S_CHECK;
          fidx <= fidx + 1'b1;
        end
        S_CHECK: begin
          if (!d_own) begin
            if (first_desc) begin
              ru_q <= 1'b1;
              ri_q <= 1'b1;
              susp <= 1'b1;
              st   <= S_DROP;
            end else begin
              last_flag <= 1'b1;
              de_flag   <= !flush_ctl;
              st        <= S_WBACK;
            end
          end else begin
            bsel <= 1'b0;
            st   <= S_BUFSEL;
          end
        end
        S_BUFSEL: begin
          if (!bsel) begin
            if (d_sz1 != '0) begin
              buf_addr <= {d_b1, 2'b00};
              buf_left <= d_sz1;
              st       <= S_XFER;
            end else begin
              bsel <= 1'b1;
            end
          end else if (!d_chn && d_sz2 != '0) begin
            buf_addr <= {d_link[AW-1:2], 2'b00};
            buf_left <= d_sz2;
            st       <= S_XFER;
          end else begin
            st <= S_WBACK;
          end
        end
        S_XFER: if (take) begin
          total    <= total + 1'b1;
          buf_left <= buf_left - 1'b1;
          if (src_final) fin <= 1'b1;
          if (lane == LW'(LANES - 1) || buf_left == BSZ_W'(1) || src_final)
            st <= S_WDATA;
        end
        S_WDATA: if (mem_ready) begin
          buf_addr <= buf_addr + AW'(LANES);
          if (fin) begin
            last_flag <= 1'b1;
            st        <= S_WBACK;
          end else if (buf_left == '0) begin
            if (!bsel) begin
              bsel <= 1'b1;
              st   <= S_BUFSEL;
            end else begin
              st <= S_WBACK;
            end
          end else begin
            st <= S_XFER;
          end
        end
        S_WBACK: if (mem_ready) begin
          first_desc <= 1'b0;
          if (last_flag) begin
            if (!d_dic) ri_q <= 1'b1;
            cur_desc <= nxt;
            st       <= stream_done ? S_IDLE : S_DROP;
          end else begin
            desc_addr <= nxt;
            fidx      <= '0;
            st        <= S_FETCH;
          end
        end
        S_DROP: if (s_valid && s_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      S_IDLE:            ps = !en ? PS_STOPPED : (susp ? PS_SUSP : PS_WAIT);
      S_FETCH, S_CHECK:  ps = first_desc ? PS_FETCH : PS_XFER;
      S_WBACK:           ps = last_flag ? PS_CLOSE : PS_XFER;
      S_DROP:            ps = susp ? PS_SUSP : PS_WAIT;
      default:           ps = PS_XFER;
    endcase
  end

  assign proc_state = ps;
  assign ev_ri      = ri_q;
  assign ev_ru      = ru_q;
  assign desc_ptr   = cur_desc;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata) && $stable(mem_be)));

  // R1
  gated_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !en) |=> (st == S_IDLE));

  // R3
  ru_suspends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ru |-> (proc_state == 3'd4));

  // R5
  no_buf_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (buf_left != '0));

endmodule

// File: tb/rxring_dma_tb_top.sv
`timescale 1ns/1ps
module rxring_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mac_rx_en = 1'b0, dma_rx_start = 1'b0, flush_ctl = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_ready, mem_req, mem_we, mem_ready, ev_ri, ev_ru;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, desc_ptr;
  logic [3:0]  mem_be;
  logic [2:0]  proc_state;

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, ri_cnt = 0, ru_cnt = 0, req_cnt = 0;
  logic [31:0] first_rd;
  logic [2:0]  slog [16];
  int          slen = 0;
  bit          finished = 0;

  logic [31:0] mem [0:511];
  logic        ready_q;

  always #2.5 clk = ~clk;

  rxring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .mac_rx_en(mac_rx_en), .dma_rx_start(dma_rx_start),
    .flush_ctl(flush_ctl), .ring_base(ring_base), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .proc_state(proc_state), .ev_ri(ev_ri), .ev_ru(ev_ru),
    .desc_ptr(desc_ptr)
  );

  // memory model: every beat waits one cycle
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= mem_req && !ready_q;
  assign mem_ready = ready_q;
  assign mem_rdata = mem[mem_addr[10:2]];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        if (rd_cnt == 0) first_rd <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (mem_req) req_cnt <= req_cnt + 1;
    if (ev_ri) ri_cnt <= ri_cnt + 1;
    if (ev_ru) ru_cnt <= ru_cnt + 1;
  end

  always @(negedge clk)
    if (slen == 0 || (slen < 16 && slog[slen-1] != proc_state)) begin
      slog[slen] = proc_state;
      slen++;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w1(input bit dic, input bit eor, input bit chn,
                                     input int sz2, input int sz1);
    return {dic, 5'b0, eor, chn, 2'b0, 11'(sz2), 11'(sz1)};
  endfunction

  task automatic put_desc(input int a, input logic [31:0] d0, input logic [31:0] d1,
                          input logic [31:0] d2, input logic [31:0] d3);
    mem[a/4] = d0; mem[a/4+1] = d1; mem[a/4+2] = d2; mem[a/4+3] = d3;
  endtask

  task automatic clear_mon();
    rd_cnt = 0; wr_cnt = 0; ri_cnt = 0; ru_cnt = 0; req_cnt = 0;
    slen = 0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      bit acc;
      s_valid = 1'b1;
      s_data  = seed + 8'(i);
      s_last  = (i == n - 1);
      do begin
        #1 acc = s_ready;
        @(negedge clk);
      end while (!acc);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset state", 32'(proc_state), 32'd0);
    chk("R1 reset ready", 32'(s_ready), 32'd0);
    chk("R2 reset pointer", desc_ptr, 32'h0);
  endtask

  task automatic t_disabled();
    bit seen = 0;
    clear_mon();
    mac_rx_en = 1'b1;
    s_valid = 1'b1; s_data = 8'h55; s_last = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (s_ready) seen = 1;
    end
    s_valid = 1'b0;
    @(negedge clk);
    chk("R1 ready while dma off", 32'(seen), 32'd0);
    chk("R1 no mem request while off", 32'(req_cnt), 32'd0);
    chk("R1 stopped code", 32'(proc_state), 32'd0);
    dma_rx_start = 1'b1;
    @(negedge clk);
    chk("R1 waiting code", 32'(proc_state), 32'd3);
  endtask

  task automatic t_single();
    put_desc(32'h100, 32'h8000_0000, w1(0, 0, 0, 0, 64), 32'h200, 32'h0);
    clear_mon();
    send_frame(10, 8'h10);
    chk("R2 first fetch from base", first_rd, 32'h100);
    chk("R3 four descriptor reads", 32'(rd_cnt), 32'd4);
    chk("R4 word0", mem[32'h200/4], 32'h1312_1110);
    chk("R4 word1", mem[32'h204/4], 32'h1716_1514);
    chk("R4 fcs zeros", mem[32'h208/4], 32'h0000_1918);
    chk("R4 partial strobes", mem[32'h20C/4], 32'hAAAA_0000);
    chk("R7 writeback", mem[32'h100/4], 32'h000E_0300);
    chk("R6 sequential next", desc_ptr, 32'h110);
    chk("R9 interrupt raised", 32'(ri_cnt), 32'd1);
    chk("R4 write beats", 32'(wr_cnt), 32'd5);
    chk("R10 length of state trace", 32'(slen), 32'd5);
    chk("R10 state 0", 32'(slog[0]), 32'd3);
    chk("R10 state 1", 32'(slog[1]), 32'd1);
    chk("R10 state 2", 32'(slog[2]), 32'd7);
    chk("R10 state 3", 32'(slog[3]), 32'd5);
    chk("R10 state 4", 32'(slog[4]), 32'd3);
  endtask

  task automatic t_two_buffers_wrap();
    put_desc(32'h110, 32'h8000_0000, w1(0, 1, 0, 8, 8), 32'h300, 32'h340);
    clear_mon();
    send_frame(12, 8'h40);
    chk("R5 buffer1 a", mem[32'h300/4], 32'h4342_4140);
    chk("R5 buffer1 b", mem[32'h304/4], 32'h4746_4544);
    chk("R5 buffer2 data", mem[32'h340/4], 32'h4B4A_4948);
    chk("R5 buffer2 fcs", mem[32'h344/4], 32'h0000_0000);
    chk("R7 two-buffer writeback", mem[32'h110/4], 32'h0010_0300);
    chk("R6 end of ring wraps", desc_ptr, 32'h100);
  endtask

  task automatic t_chain();
    put_desc(32'h100, 32'h8000_0000, w1(0, 0, 1, 8, 8), 32'h400, 32'h180);
    put_desc(32'h180, 32'h8000_0000, w1(1, 0, 0, 0, 16), 32'h440, 32'h0);
    clear_mon();
    send_frame(10, 8'h60);
    chk("R5 first descriptor buffer", mem[32'h400/4], 32'h6362_6160);
    chk("R5 first descriptor buffer b", mem[32'h404/4], 32'h6766_6564);
    chk("R5 chain word not a buffer", mem[32'h408/4], 32'hAAAA_AAAA);
    chk("R6 chained fetch data", mem[32'h440/4], 32'h0000_6968);
    chk("R4 chained tail strobes", mem[32'h444/4], 32'hAAAA_0000);
    chk("R7 first segment", mem[32'h100/4], 32'h0008_0200);
    chk("R7 last segment", mem[32'h180/4], 32'h000E_0100);
    chk("R9 completion interrupt disabled", 32'(ri_cnt), 32'd0);
    chk("R3 eight reads", 32'(rd_cnt), 32'd8);
    chk("R6 next after chained", desc_ptr, 32'h190);
  endtask

  task automatic t_midframe_unowned(input bit fl, input int d, input int b, input logic [7:0] seed,
                                    input logic [31:0] exp_end);
    flush_ctl = fl;
    put_desc(d, 32'h8000_0000, w1(0, 0, 0, 0, 4), b, 32'h0);
    put_desc(d + 16, 32'h0, 32'h0, 32'h0, 32'h0);
    clear_mon();
    send_frame(10, seed);
    chk("R8 stored part", mem[b/4], {seed + 8'd3, seed + 8'd2, seed + 8'd1, seed});
    chk("R8 rest discarded", mem[b/4 + 1], 32'hAAAA_AAAA);
    chk("R7 non-last writeback", mem[d/4], 32'h0004_0200);
    chk(fl ? "R8 end with flush" : "R8 end with error", mem[(d + 16)/4], exp_end);
    chk("R9 interrupt on truncated frame", 32'(ri_cnt), 32'd1);
    chk("R6 pointer past unowned", desc_ptr, 32'(d + 32));
    chk("R10 back to waiting", 32'(proc_state), 32'd3);
    flush_ctl = 1'b0;
  endtask

  task automatic t_first_unowned();
    put_desc(32'h1D0, 32'h0, 32'h0, 32'h600, 32'h0);
    clear_mon();
    send_frame(6, 8'hC0);
    chk("R3 unavailable pulse", 32'(ru_cnt), 32'd1);
    chk("R3 interrupt pulse", 32'(ri_cnt), 32'd1);
    chk("R3 suspended code", 32'(proc_state), 32'd4);
    chk("R3 no writes", 32'(wr_cnt), 32'd0);
    chk("R3 descriptor kept", mem[32'h1D0/4], 32'h0);
    chk("R3 pointer unchanged", desc_ptr, 32'h1D0);
    chk("R3 ready after discard", 32'(s_ready), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 32'hAAAA_AAAA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_single();
    t_two_buffers_wrap();
    t_chain();
    t_midframe_unowned(1'b0, 32'h190, 32'h500, 8'h80, 32'h0004_4100);
    t_midframe_unowned(1'b1, 32'h1B0, 32'h540, 8'h90, 32'h0004_0100);
    t_first_unowned();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule